// File: doc/BRIEF.md
# Linear-Step Beetle Search Engine

This block is a sequential optimiser that walks one point through a two-dimensional
gain space, one axis for a proportional gain and one for an integral gain. Every
iteration it takes a direction pair from an outside random source. It places two
probe points on opposite sides of the current point, a fixed sensing distance away
along that direction. It hands both probes to an external fitness evaluator over a
valid/ready request and a valid response, then waits for the two scores.

The engine moves the point along the latched direction. The step is chosen by which
probe scored worse, and its length shrinks linearly with the iteration index. The new
position is clamped to per-axis limits. The engine also tracks the lowest score seen
and the probe point that produced it. All real quantities are signed fixed point with
ten fraction bits, so 1.0 is 1024.

A run is started by a one-cycle `start` pulse and lasts a fixed number of iterations.
While it runs, `iterValid` is high. After the last iteration the flag falls and the
current position, the best position and the best score hold until the next start.

Top module: `beetle_search_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `iterValid`, `fitReqValid` and `iterCount` are 0. The positions, probe points and best point are 0, and `bestFit` is all ones.
- R2: A `start` pulse seen at a clock edge while the engine is idle or finished has a defined effect from the next cycle on. `posKp`/`posKi` and `bestKp`/`bestKi` equal `initKp`/`initKi`, `bestFit` is all ones, `iterCount` is 0 and `iterValid` is 1. A `start` pulse during a run has no effect.
- R3: In the first cycle of each iteration the engine samples the direction `dirKp`/`dirKi` (signed, ten fraction bits). It computes, per axis, the offset o = floor(972·b/1024). It registers right = pos + o and left = pos − o, each saturated to the signed coordinate range. The probe points are visible from the next cycle.
- R4: `fitReqValid` rises the cycle after the direction is sampled. It stays high, with the probe outputs stable, until a clock edge where `fitReqReady` is also high, and it is low in the cycle after that edge.
- R5: The scores on `fitLeft`/`fitRight` are taken only at an edge where `fitRspValid` is high and the request was accepted at an earlier edge. A `fitRspValid` before or at the request acceptance is ignored.
- R6: The step for iteration t (t = `iterCount`) is max(819 − 4·t, 410). The per-axis move is floor(step·b/1024), where b is the direction sampled for that iteration.
- R7: The direction bit is 1 when `fitLeft` > `fitRight` (unsigned), and 0 otherwise. With the bit at 1 each coordinate is decreased by its move; at 0 it is increased. The result is clamped to [`minKp`,`maxKp`] and [`minKi`,`maxKi`]. The position changes two cycles after the response edge and holds otherwise.
- R8: The candidate score is `fitRight` with the right probe when the direction bit is 1, and `fitLeft` with the left probe otherwise. `bestFit` and the best point take the candidate only when its score is strictly below `bestFit`. The change is visible three cycles after the response edge.
- R9: `iterCount` increases by one three cycles after each response edge. After 200 iterations `iterValid` is 0, and every output holds its value until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle or finished |
| initKp | input | 16 | Starting proportional coordinate |
| initKi | input | 16 | Starting integral coordinate |
| minKp | input | 16 | Lower clamp, proportional axis |
| maxKp | input | 16 | Upper clamp, proportional axis |
| minKi | input | 16 | Lower clamp, integral axis |
| maxKi | input | 16 | Upper clamp, integral axis |
| dirKp | input | 12 | Random direction component, proportional axis |
| dirKi | input | 12 | Random direction component, integral axis |
| fitReqValid | output | 1 | Probe points are offered for scoring |
| fitReqReady | input | 1 | Evaluator accepts the probe points |
| leftKp | output | 16 | Left probe, proportional axis |
| leftKi | output | 16 | Left probe, integral axis |
| rightKp | output | 16 | Right probe, proportional axis |
| rightKi | output | 16 | Right probe, integral axis |
| fitRspValid | input | 1 | Scores are present |
| fitLeft | input | 24 | Score of the left probe |
| fitRight | input | 24 | Score of the right probe |
| posKp | output | 16 | Current proportional coordinate |
| posKi | output | 16 | Current integral coordinate |
| bestKp | output | 16 | Best proportional coordinate found |
| bestKi | output | 16 | Best integral coordinate found |
| bestFit | output | 24 | Lowest score found |
| iterValid | output | 1 | A run is in progress |
| iterCount | output | 8 | Completed iterations of the current run |

## Verification
A wrong sequencer state shows at once as a `fitReqValid` or `iterValid` that differs
from the reference in the same cycle. A dropped or doubled count shifts the step
length, and the position error appears at the next move, at most a few cycles later.
A wrong latched direction or score, or a wrong clamp, appears in the probe or position
outputs one or two cycles after the corrupted register is loaded. A wrong best-point
decision appears one cycle after the iteration's final state. Because every output is
compared against the reference on every clock, each such divergence is caught within
the iteration in which it occurs.

// File: rtl/beetle_pkg.sv
package beetle_pkg;
  localparam int NUM_DIM = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ANTENNA,
    ST_WAIT_FIT,
    ST_MOVE,
    ST_BEST,
    ST_DONE
  } bState_t;

  typedef struct packed {
    logic loadInit;
    logic latchAnt;
    logic latchFit;
    logic doMove;
    logic doBest;
  } dpStrobe_t;
endpackage

// File: rtl/beetle_ctrl.sv
module beetle_ctrl
  import beetle_pkg::*;
#(
  parameter int ITER_MAX = 200,
  localparam int CNT_W = $clog2(ITER_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             fitReqReady,
  input  logic             fitRspValid,
  output dpStrobe_t        strobe,
  output logic             fitReqValid,
  output logic             iterValid,
  output logic [CNT_W-1:0] iterCount
);
  bState_t          state;
  logic             reqSent;
  logic [CNT_W-1:0] iterCnt;
  logic             idleLike;
  logic             lastIter;

  assign idleLike = (state == ST_IDLE) || (state == ST_DONE);
  assign lastIter = (iterCnt == CNT_W'(ITER_MAX - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reqSent <= 1'b0;
      iterCnt <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state   <= ST_ANTENNA;
            iterCnt <= '0;
          end
        end
        ST_ANTENNA: begin
          state   <= ST_WAIT_FIT;
          reqSent <= 1'b0;
        end
        ST_WAIT_FIT: begin
          if (reqSent && fitRspValid) begin
            state <= ST_MOVE;
          end else if (!reqSent && fitReqReady) begin
            reqSent <= 1'b1;
          end
        end
        ST_MOVE: state <= ST_BEST;
        ST_BEST: begin
          iterCnt <= iterCnt + 1'b1;
          state   <= lastIter ? ST_DONE : ST_ANTENNA;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadInit = idleLike && start;
    strobe.latchAnt = (state == ST_ANTENNA);
    strobe.latchFit = (state == ST_WAIT_FIT) && reqSent && fitRspValid;
    strobe.doMove   = (state == ST_MOVE);
    strobe.doBest   = (state == ST_BEST);
  end

  assign fitReqValid = (state == ST_WAIT_FIT) && !reqSent;
  assign iterValid   = !idleLike;
  assign iterCount   = iterCnt;
endmodule

// File: rtl/beetle_axis.sv
module beetle_axis
  import beetle_pkg::*;
#(
  parameter int COORD_W    = 16,
  parameter int DIR_W      = 12,
  parameter int FRAC_W     = 10,
  parameter int STEP_W     = 11,
  parameter int SENSE_DIST = 972
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic                      decrease,
  input  logic                      takeBest,
  input  logic signed [COORD_W-1:0] initVal,
  input  logic signed [COORD_W-1:0] minVal,
  input  logic signed [COORD_W-1:0] maxVal,
  input  logic signed [DIR_W-1:0]   dirIn,
  input  logic signed [STEP_W-1:0]  stepCur,
  output logic signed [COORD_W-1:0] pos,
  output logic signed [COORD_W-1:0] left,
  output logic signed [COORD_W-1:0] right,
  output logic signed [COORD_W-1:0] best
);
  localparam int MUL_W = DIR_W + FRAC_W + 2;
  localparam int SUM_W = ((MUL_W > COORD_W) ? MUL_W : COORD_W) + 2;
  localparam logic signed [SUM_W-1:0] CMAX = SUM_W'((2 ** (COORD_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] CMIN = -CMAX - SUM_W'(1);

  logic signed [DIR_W-1:0] dirReg;
  logic signed [MUL_W-1:0] senseOff, moveOff;
  logic signed [SUM_W-1:0] posW, rightW, leftW, moveW;
  logic signed [SUM_W-1:0] rightSat, leftSat, moveClamp;

  always_comb begin
    senseOff = (MUL_W'(dirIn) * MUL_W'(SENSE_DIST)) >>> FRAC_W;
    moveOff  = (MUL_W'(dirReg) * MUL_W'(stepCur)) >>> FRAC_W;
    posW     = SUM_W'(pos);
    rightW   = posW + SUM_W'(senseOff);
    leftW    = posW - SUM_W'(senseOff);
    moveW    = decrease ? (posW - SUM_W'(moveOff)) : (posW + SUM_W'(moveOff));

    if (rightW > CMAX)      rightSat = CMAX;
    else if (rightW < CMIN) rightSat = CMIN;
    else                    rightSat = rightW;

    if (leftW > CMAX)      leftSat = CMAX;
    else if (leftW < CMIN) leftSat = CMIN;
    else                   leftSat = leftW;

    if (moveW > SUM_W'(maxVal))      moveClamp = SUM_W'(maxVal);
    else if (moveW < SUM_W'(minVal)) moveClamp = SUM_W'(minVal);
    else                             moveClamp = moveW;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg <= '0;
      pos    <= '0;
      left   <= '0;
      right  <= '0;
      best   <= '0;
    end else begin
      if (strobe.loadInit) begin
        pos  <= initVal;
        best <= initVal;
      end
      if (strobe.latchAnt) begin
        dirReg <= dirIn;
        right  <= COORD_W'(rightSat);
        left   <= COORD_W'(leftSat);
      end
      if (strobe.doMove) pos <= COORD_W'(moveClamp);
      if (strobe.doBest && takeBest) best <= decrease ? right : left;
    end
  end
endmodule

// File: rtl/beetle_dp.sv
module beetle_dp
  import beetle_pkg::*;
#(
  parameter int COORD_W    = 16,
  parameter int DIR_W      = 12,
  parameter int FIT_W      = 24,
  parameter int FRAC_W     = 10,
  parameter int SENSE_DIST = 972,
  parameter int STEP_MAX   = 819,
  parameter int STEP_DEC   = 4,
  parameter int STEP_MIN   = 410,
  parameter int CNT_W      = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [CNT_W-1:0]          iterCount,
  input  logic signed [COORD_W-1:0] initKp,
  input  logic signed [COORD_W-1:0] initKi,
  input  logic signed [COORD_W-1:0] minKp,
  input  logic signed [COORD_W-1:0] maxKp,
  input  logic signed [COORD_W-1:0] minKi,
  input  logic signed [COORD_W-1:0] maxKi,
  input  logic signed [DIR_W-1:0]   dirKp,
  input  logic signed [DIR_W-1:0]   dirKi,
  input  logic [FIT_W-1:0]          fitLeft,
  input  logic [FIT_W-1:0]          fitRight,
  output logic signed [COORD_W-1:0] leftKp,
  output logic signed [COORD_W-1:0] leftKi,
  output logic signed [COORD_W-1:0] rightKp,
  output logic signed [COORD_W-1:0] rightKi,
  output logic signed [COORD_W-1:0] posKp,
  output logic signed [COORD_W-1:0] posKi,
  output logic signed [COORD_W-1:0] bestKp,
  output logic signed [COORD_W-1:0] bestKi,
  output logic [FIT_W-1:0]          bestFit
);
  localparam int STEP_W = $clog2(STEP_MAX + 1) + 1;

  logic [FIT_W-1:0] fitL, fitR, candFit;
  logic             decrease, takeBest;
  logic signed [31:0]       stepRaw;
  logic signed [STEP_W-1:0] stepCur;

  logic signed [COORD_W-1:0] initA [NUM_DIM];
  logic signed [COORD_W-1:0] minA  [NUM_DIM];
  logic signed [COORD_W-1:0] maxA  [NUM_DIM];
  logic signed [DIR_W-1:0]   dirA  [NUM_DIM];
  logic signed [COORD_W-1:0] posA  [NUM_DIM];
  logic signed [COORD_W-1:0] leftA [NUM_DIM];
  logic signed [COORD_W-1:0] rightA[NUM_DIM];
  logic signed [COORD_W-1:0] bestA [NUM_DIM];

  assign initA[0] = initKp;  assign initA[1] = initKi;
  assign minA[0]  = minKp;   assign minA[1]  = minKi;
  assign maxA[0]  = maxKp;   assign maxA[1]  = maxKi;
  assign dirA[0]  = dirKp;   assign dirA[1]  = dirKi;

  assign stepRaw  = 32'(STEP_MAX) - 32'(STEP_DEC) * 32'($signed({1'b0, iterCount}));
  assign stepCur  = (stepRaw < 32'(STEP_MIN)) ? STEP_W'(STEP_MIN) : STEP_W'(stepRaw);
  assign decrease = (fitL > fitR);
  assign candFit  = decrease ? fitR : fitL;
  assign takeBest = (candFit < bestFit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fitL    <= '0;
      fitR    <= '0;
      bestFit <= '1;
    end else begin
      if (strobe.latchFit) begin
        fitL <= fitLeft;
        fitR <= fitRight;
      end
      if (strobe.loadInit) bestFit <= '1;
      else if (strobe.doBest && takeBest) bestFit <= candFit;
    end
  end

  for (genvar g = 0; g < NUM_DIM; g++) begin : g_axis
    beetle_axis #(
      .COORD_W(COORD_W), .DIR_W(DIR_W), .FRAC_W(FRAC_W),
      .STEP_W(STEP_W), .SENSE_DIST(SENSE_DIST)
    ) axis_i (
      .clk(clk), .rstN(rstN), .strobe(strobe),
      .decrease(decrease), .takeBest(takeBest),
      .initVal(initA[g]), .minVal(minA[g]), .maxVal(maxA[g]),
      .dirIn(dirA[g]), .stepCur(stepCur),
      .pos(posA[g]), .left(leftA[g]), .right(rightA[g]), .best(bestA[g])
    );
  end

  assign posKp   = posA[0];   assign posKi   = posA[1];
  assign leftKp  = leftA[0];  assign leftKi  = leftA[1];
  assign rightKp = rightA[0]; assign rightKi = rightA[1];
  assign bestKp  = bestA[0];  assign bestKi  = bestA[1];
endmodule

// File: rtl/beetle_search_top.sv
module beetle_search_top
  import beetle_pkg::*;
#(
  parameter int COORD_W    = 16,
  parameter int DIR_W      = 12,
  parameter int FIT_W      = 24,
  parameter int FRAC_W     = 10,
  parameter int SENSE_DIST = 972,
  parameter int STEP_MAX   = 819,
  parameter int STEP_DEC   = 4,
  parameter int STEP_MIN   = 410,
  parameter int ITER_MAX   = 200,
  localparam int CNT_W = $clog2(ITER_MAX + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic signed [COORD_W-1:0] initKp,
  input  logic signed [COORD_W-1:0] initKi,
  input  logic signed [COORD_W-1:0] minKp,
  input  logic signed [COORD_W-1:0] maxKp,
  input  logic signed [COORD_W-1:0] minKi,
  input  logic signed [COORD_W-1:0] maxKi,
  input  logic signed [DIR_W-1:0]   dirKp,
  input  logic signed [DIR_W-1:0]   dirKi,
  output logic                      fitReqValid,
  input  logic                      fitReqReady,
  output logic signed [COORD_W-1:0] leftKp,
  output logic signed [COORD_W-1:0] leftKi,
  output logic signed [COORD_W-1:0] rightKp,
  output logic signed [COORD_W-1:0] rightKi,
  input  logic                      fitRspValid,
  input  logic [FIT_W-1:0]          fitLeft,
  input  logic [FIT_W-1:0]          fitRight,
  output logic signed [COORD_W-1:0] posKp,
  output logic signed [COORD_W-1:0] posKi,
  output logic signed [COORD_W-1:0] bestKp,
  output logic signed [COORD_W-1:0] bestKi,
  output logic [FIT_W-1:0]          bestFit,
  output logic                      iterValid,
  output logic [CNT_W-1:0]          iterCount
);
  dpStrobe_t strobe;

  beetle_ctrl #(.ITER_MAX(ITER_MAX)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .fitReqReady(fitReqReady), .fitRspValid(fitRspValid),
    .strobe(strobe), .fitReqValid(fitReqValid),
    .iterValid(iterValid), .iterCount(iterCount)
  );

  beetle_dp #(
    .COORD_W(COORD_W), .DIR_W(DIR_W), .FIT_W(FIT_W), .FRAC_W(FRAC_W),
    .SENSE_DIST(SENSE_DIST), .STEP_MAX(STEP_MAX), .STEP_DEC(STEP_DEC),
    .STEP_MIN(STEP_MIN), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .iterCount(iterCount),
    .initKp(initKp), .initKi(initKi),
    .minKp(minKp), .maxKp(maxKp), .minKi(minKi), .maxKi(maxKi),
    .dirKp(dirKp), .dirKi(dirKi),
    .fitLeft(fitLeft), .fitRight(fitRight),
    .leftKp(leftKp), .leftKi(leftKi), .rightKp(rightKp), .rightKi(rightKi),
    .posKp(posKp), .posKi(posKi), .bestKp(bestKp), .bestKi(bestKi),
    .bestFit(bestFit)
  );
endmodule

// File: rtl/beetle_chk.sv
module beetle_chk #(
  parameter int COORD_W  = 16,
  parameter int FIT_W    = 24,
  parameter int ITER_MAX = 200,
  parameter int CNT_W    = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      fitReqValid,
  input logic                      fitReqReady,
  input logic signed [COORD_W-1:0] leftKp,
  input logic signed [COORD_W-1:0] rightKi,
  input logic signed [COORD_W-1:0] posKp,
  input logic signed [COORD_W-1:0] posKi,
  input logic signed [COORD_W-1:0] minKp,
  input logic signed [COORD_W-1:0] maxKp,
  input logic signed [COORD_W-1:0] minKi,
  input logic signed [COORD_W-1:0] maxKi,
  input logic [FIT_W-1:0]          bestFit,
  input logic [CNT_W-1:0]          iterCount,
  input logic                      loadInit,
  input logic                      doMove
);
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    fitReqValid && !fitReqReady |=> fitReqValid && $stable(leftKp) && $stable(rightKi));

  a_r4_req_drop: assert property (@(posedge clk) disable iff (!rstN)
    fitReqValid && fitReqReady |=> !fitReqValid);

  a_r7_pos_clamped: assert property (@(posedge clk) disable iff (!rstN)
    doMove |=> (posKp >= minKp) && (posKp <= maxKp) && (posKi >= minKi) && (posKi <= maxKi));

  a_r8_best_never_rises: assert property (@(posedge clk) disable iff (!rstN)
    !loadInit |=> bestFit <= $past(bestFit));

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    iterCount <= CNT_W'(ITER_MAX));
endmodule

bind beetle_search_top beetle_chk #(
  .COORD_W(COORD_W), .FIT_W(FIT_W), .ITER_MAX(ITER_MAX), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .fitReqValid(fitReqValid), .fitReqReady(fitReqReady),
  .leftKp(leftKp), .rightKi(rightKi), .posKp(posKp), .posKi(posKi),
  .minKp(minKp), .maxKp(maxKp), .minKi(minKi), .maxKi(maxKi),
  .bestFit(bestFit), .iterCount(iterCount),
  .loadInit(strobe.loadInit), .doMove(strobe.doMove)
);

// File: tb/beetle_search_top_tb_top.sv
`timescale 1ns/1ps
module beetle_search_top_tb_top;
  localparam int MAXF = (1 << 24) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signed [15:0] initKp = '0, initKi = '0, minKp = '0, maxKp = '0, minKi = '0, maxKi = '0;
  logic signed [11:0] dirKp = '0, dirKi = '0;
  logic fitReqReady = 1'b0, fitRspValid = 1'b0;
  logic [23:0] fitLeft = '0, fitRight = '0;
  logic fitReqValid, iterValid;
  logic signed [15:0] leftKp, leftKi, rightKp, rightKi, posKp, posKi, bestKp, bestKi;
  logic [23:0] bestFit;
  logic [7:0] iterCount;

  always #2.5 clk = ~clk;

  beetle_search_top dut_i (.*);

  int checks = 0, errors = 0;
  bit cmpOn = 0, finished = 0;
  int tgtKp = 0, tgtKi = 0;
  int unsigned rnd = 32'h1234_5678;

  // reference model state
  int mPh = 0, mPk = 0, mPi = 0, mBk = 0, mBi = 0, mBf = MAXF, mIt = 0;
  int mDk = 0, mDi = 0, mLk = 0, mLi = 0, mRk = 0, mRi = 0, mFl = 0, mFr = 0;
  bit mSent = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int clampTo(int v, int lo, int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int absI(int v);
    return (v < 0) ? -v : v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mPk = 0; mPi = 0; mBk = 0; mBi = 0; mBf = MAXF; mIt = 0;
      mLk = 0; mLi = 0; mRk = 0; mRi = 0; mSent = 0; mDk = 0; mDi = 0;
    end else begin
      case (mPh)
        0, 5: if (start) begin
          mPk = initKp; mPi = initKi; mBk = initKp; mBi = initKi;
          mBf = MAXF; mIt = 0; mPh = 1;
        end
        1: begin
          mDk = dirKp; mDi = dirKi;
          mRk = sat16(mPk + ((972 * mDk) >>> 10)); mLk = sat16(mPk - ((972 * mDk) >>> 10));
          mRi = sat16(mPi + ((972 * mDi) >>> 10)); mLi = sat16(mPi - ((972 * mDi) >>> 10));
          mSent = 0; mPh = 2;
        end
        2: begin
          if (mSent && fitRspValid) begin
            mFl = fitLeft; mFr = fitRight; mPh = 3;
          end else if (!mSent && fitReqReady) mSent = 1;
        end
        3: begin
          int st;
          st = 819 - 4 * mIt;
          if (st < 410) st = 410;
          if (mFl > mFr) begin
            mPk = clampTo(mPk - ((st * mDk) >>> 10), minKp, maxKp);
            mPi = clampTo(mPi - ((st * mDi) >>> 10), minKi, maxKi);
          end else begin
            mPk = clampTo(mPk + ((st * mDk) >>> 10), minKp, maxKp);
            mPi = clampTo(mPi + ((st * mDi) >>> 10), minKi, maxKi);
          end
          mPh = 4;
        end
        4: begin
          if (mFl > mFr) begin
            if (mFr < mBf) begin mBf = mFr; mBk = mRk; mBi = mRi; end
          end else begin
            if (mFl < mBf) begin mBf = mFl; mBk = mLk; mBi = mLi; end
          end
          mIt++;
          mPh = (mIt == 200) ? 5 : 1;
        end
        default: mPh = 0;
      endcase
    end
  end

  // stimulus for direction and fitness interface, plus per-cycle comparison
  always @(negedge clk) begin
    bit tie;
    rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
    dirKp = rnd[11:0];
    dirKi = rnd[23:12];
    fitReqReady = rnd[24] | rnd[25];
    fitRspValid = rnd[26] | rnd[27];
    tie = (rnd[31:29] == 3'd0);
    fitLeft = 24'(absI(leftKp - tgtKp) + absI(leftKi - tgtKi));
    fitRight = tie ? fitLeft : 24'(absI(rightKp - tgtKp) + absI(rightKi - tgtKi));
    if (cmpOn) begin
      chk("R5/R9 iterValid", int'(iterValid), int'(mPh >= 1 && mPh <= 4));
      chk("R9 iterCount", int'(iterCount), mIt);
      chk("R4 fitReqValid", int'(fitReqValid), int'(mPh == 2 && !mSent));
      chk("R3 leftKp", int'(leftKp), mLk);
      chk("R3 leftKi", int'(leftKi), mLi);
      chk("R3 rightKp", int'(rightKp), mRk);
      chk("R3 rightKi", int'(rightKi), mRi);
      chk("R6/R7 posKp", int'(posKp), mPk);
      chk("R6/R7 posKi", int'(posKi), mPi);
      chk("R8 bestKp", int'(bestKp), mBk);
      chk("R8 bestKi", int'(bestKi), mBi);
      chk("R8 bestFit", int'(bestFit), mBf);
    end
  end

  task automatic runOnce(int iKp, int iKi, int loK, int hiK, int loI, int hiI, int tK, int tI);
    @(negedge clk);
    initKp = 16'(iKp); initKi = 16'(iKi);
    minKp = 16'(loK); maxKp = 16'(hiK); minKi = 16'(loI); maxKi = 16'(hiI);
    tgtKp = tK; tgtKi = tI;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: the run begins from the programmed start point
    chk("R2 iterValid after start", int'(iterValid), 1);
    chk("R2 iterCount after start", int'(iterCount), 0);
    chk("R2 posKp loaded", int'(posKp), iKp);
    chk("R2 bestKi loaded", int'(bestKi), iKi);
    chk("R2 bestFit cleared", int'(bestFit), MAXF);
    while (iterCount != 8'd50) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 start mid-run ignored", int'(iterCount), 50);
    while (mPh != 5) @(negedge clk);
    @(negedge clk);
    chk("R9 run length", int'(iterCount), 200);
    chk("R9 iterValid low when done", int'(iterValid), 0);
    repeat (6) @(negedge clk);
    chk("R9 pos held after done", int'(posKp), mPk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    cmpOn = 1;
    @(negedge clk);
    // R1: reset values
    chk("R1 iterValid in reset", int'(iterValid), 0);
    chk("R1 fitReqValid in reset", int'(fitReqValid), 0);
    chk("R1 bestFit in reset", int'(bestFit), MAXF);
    chk("R1 posKp in reset", int'(posKp), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'(iterValid), 0);
    runOnce(1024, 2048, -4096, 8192, -4096, 8192, 3000, -1500);
    runOnce(1000, 2000, 900, 1100, 1900, 2100, 5000, 5000);
    runOnce(32700, -32700, 30000, 32767, -32768, -30000, 32767, -32768);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule